// File: doc/BRIEF.md
# Serial Host Control Port with Read-Request Handshake

This block is the slave side of a four-wire serial control link. It sits between an external host that drives a serial clock, a chip select and a data line, and an internal byte-wide processor interface. The serial clock and chip select are oversampled by the fast system clock, so all logic runs in one clock domain. Every transaction opens with an address byte. Its upper seven bits name the target device and its lowest bit gives the direction. After a matching write header, each complete byte the host sends is passed inward on a valid/ready stream. After a matching read header, bytes are taken from an internal valid/ready source and shifted back to the host.

An active-low request line tells the host that read data is waiting, so the host needs no length field. The host keeps clocking bytes out while the line is low. When the source is empty during a read byte, the line rises just after the rising clock edge of the byte's seventh bit. It then stays high until the rising edge of the eighth bit, even if new data arrives in between. A write byte is only passed inward on the falling clock edge that follows its eighth bit. A byte cut short by a missing final edge or by chip select rising is lost.

Top module: `spi_host_port`

## Requirements
- R1: After reset, req_n_o is high while rd_valid_i is low, wr_valid_o is low, miso_o is low, the device address is 0000000b and address checking is enabled.
- R2: When the upper seven bits of the header byte differ from the device address and checking is enabled, the transaction has no effect: no write byte is presented and no read byte is popped.
- R3: Bits travel most significant first and are sampled on the rising serial clock edge. The header byte carries the address in bits 7:1 and the direction in bit 0, where 0 selects write and 1 selects read.
- R4: A pulse on cfg_we_i loads cfg_addr_i as the device address and cfg_chk_en_i as the check enable. With the check enable at 0, any header address is accepted.
- R5: A received write byte is presented on wr_data_o only after the falling serial clock edge that follows its eighth bit. A byte without that falling edge is never presented.
- R6: A write transaction may carry any number of whole bytes, and they are presented in the order they were sent.
- R7: Outside the hold window of R8, req_n_o is low whenever rd_valid_i is high and high whenever it is low.
- R8: During a read byte, if rd_valid_i is low at the rising edge of bit 7, req_n_o goes high and stays high until the rising edge of bit 8, even if data arrives in between.
- R9: Read data changes on falling edges. The next read byte is loaded on the falling edge after bit 8 of the previous byte (the header for the first one) and is popped with a one-cycle rd_ready_o pulse. If the source is empty at that point, 0x00 is shifted out and nothing is popped.
- R10: wr_valid_o stays high with wr_data_o unchanged until wr_ready_i accepts the byte.
- R11: Raising chip select aborts the transaction and drops any partial byte. The next transaction starts again with a header byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| cs_n_i | input | 1 | Active-low chip select from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| req_n_o | output | 1 | Active-low read-data-waiting request |
| cfg_we_i | input | 1 | Write strobe for the address configuration |
| cfg_addr_i | input | ADDR_W | New device address |
| cfg_chk_en_i | input | 1 | New address-check enable |
| wr_data_o | output | DATA_W | Received write byte |
| wr_valid_o | output | 1 | Write byte valid |
| wr_ready_i | input | 1 | Internal side accepts the write byte |
| rd_data_i | input | DATA_W | Next byte to send to the host |
| rd_valid_i | input | 1 | Read source has a byte |
| rd_ready_o | output | 1 | Pop pulse for the read source |

## Verification
The bench builds the block with its default parameters: 7-bit address, 8-bit bytes and a two-flop synchronizer. It drives the serial clock with a half-period of eight system clocks, which leaves every serial edge several cycles clear of the three-cycle detection latency. With that spacing the bench can probe between individual serial edges. It checks that nothing is presented after the eighth rising edge before the falling edge, and it injects read data between the seventh and eighth rising edges to observe the hold window. It also samples the output line after each falling edge.

// File: rtl/spi_hp_pkg.sv
package spi_hp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_WRITE = 3'd2,
    PH_READ  = 3'd3,
    PH_SKIP  = 3'd4
  } phase_e;
endpackage

// File: rtl/spi_hp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
module spi_hp_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_in;
      if (s == 0) begin : g_first
        assign stg_in = d_i;
      end else begin : g_rest
        assign stg_in = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_in;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_hp_edge.sv
// Rise/fall pulse generator on a synchronized level.
module spi_hp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_hp_ctrl.sv
// Transaction sequencer: header decode, bit counting, shift registers.
module spi_hp_ctrl
  import spi_hp_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              chk_en_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  output logic              rd_pop_o,
  output logic              wr_push_o,
  output logic [DATA_W-1:0] wr_byte_o,
  output logic              miso_o,
  output logic              warn_rise_o,
  output logic              last_rise_o,
  output phase_e            phase_o,
  output logic [$clog2(DATA_W+1)-1:0] cnt_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_WARN = CNT_W'(DATA_W - 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  phase_e             phase_q, phase_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [DATA_W-1:0]  rx_q, rx_n;
  logic [DATA_W-1:0]  tx_q, tx_n;
  logic               addr_ok;

  assign addr_ok = !chk_en_i || (rx_q[DATA_W-1 -: ADDR_W] == own_addr_i);

  always_comb begin
    phase_n   = phase_q;
    cnt_n     = cnt_q;
    rx_n      = rx_q;
    tx_n      = tx_q;
    rd_pop_o  = 1'b0;
    wr_push_o = 1'b0;
    if (!cs_act_i) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
      tx_n    = '0;
    end else if (phase_q == PH_IDLE) begin
      phase_n = PH_ADDR;
      cnt_n   = '0;
    end else begin
      if (sclk_rise_i && cnt_q != CNT_FULL) begin
        rx_n  = {rx_q[DATA_W-2:0], mosi_i};
        cnt_n = cnt_q + CNT_W'(1);
      end
      if (sclk_fall_i) begin
        if (cnt_q == CNT_FULL) begin
          cnt_n = '0;
          unique case (phase_q)
            PH_ADDR: begin
              if (!addr_ok)     phase_n = PH_SKIP;
              else if (rx_q[0]) phase_n = PH_READ;
              else              phase_n = PH_WRITE;
            end
            PH_WRITE: wr_push_o = 1'b1;
            default: ;
          endcase
          if ((phase_q == PH_ADDR && addr_ok && rx_q[0]) || phase_q == PH_READ) begin
            tx_n     = rd_valid_i ? rd_data_i : '0;
            rd_pop_o = rd_valid_i;
          end
        end else if (phase_q == PH_READ && cnt_q != '0) begin
          tx_n = {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
    end
  end

  assign wr_byte_o   = rx_q;
  assign miso_o      = tx_q[DATA_W-1];
  assign warn_rise_o = sclk_rise_i && phase_q == PH_READ && cnt_q == CNT_WARN;
  assign last_rise_o = sclk_rise_i && phase_q == PH_READ && cnt_q == CNT_LAST;
  assign phase_o     = phase_q;
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/spi_hp_req.sv
// Active-low read request with the late-byte hold window.
module spi_hp_req (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act_i,
  input  logic warn_rise_i,
  input  logic last_rise_i,
  input  logic rd_valid_i,
  output logic hold_o,
  output logic req_n_o
);
  logic hold_q, hold_n;
  logic req_q, req_n;

  always_comb begin
    hold_n = hold_q;
    if (!cs_act_i || last_rise_i)        hold_n = 1'b0;
    else if (warn_rise_i && !rd_valid_i) hold_n = 1'b1;
    req_n = hold_n | ~rd_valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      req_q  <= 1'b1;
    end else begin
      hold_q <= hold_n;
      req_q  <= req_n;
    end
  end

  assign hold_o  = hold_q;
  assign req_n_o = req_q;
endmodule

// File: rtl/spi_host_port.sv
module spi_host_port
  import spi_hp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned DATA_W      = ADDR_W + 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              req_n_o,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_chk_en_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  output logic              rd_ready_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [2:0]        line_s;
  logic              cs_act, sclk_rise, sclk_fall;
  logic [ADDR_W-1:0] own_addr_q, own_addr_n;
  logic              chk_en_q, chk_en_n;
  logic              wr_push, req_hold, warn_rise, last_rise;
  logic [DATA_W-1:0] wr_byte, wr_data_q, wr_data_n;
  logic              wr_valid_q, wr_valid_n;
  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;

  spi_hp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({cs_n_i, sclk_i, mosi_i}), .q_o(line_s)
  );

  assign cs_act = ~line_s[2];

  spi_hp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(line_s[1]),
    .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  spi_hp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .mosi_i(line_s[0]),
    .own_addr_i(own_addr_q), .chk_en_i(chk_en_q),
    .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i), .rd_pop_o(rd_ready_o),
    .wr_push_o(wr_push), .wr_byte_o(wr_byte), .miso_o(miso_o),
    .warn_rise_o(warn_rise), .last_rise_o(last_rise),
    .phase_o(phase), .cnt_o(bit_cnt)
  );

  spi_hp_req u_req (
    .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act),
    .warn_rise_i(warn_rise), .last_rise_i(last_rise),
    .rd_valid_i(rd_valid_i), .hold_o(req_hold), .req_n_o(req_n_o)
  );

  // Configuration and inward write holding register
  always_comb begin
    own_addr_n = own_addr_q;
    chk_en_n   = chk_en_q;
    if (cfg_we_i) begin
      own_addr_n = cfg_addr_i;
      chk_en_n   = cfg_chk_en_i;
    end
    wr_data_n  = wr_data_q;
    wr_valid_n = wr_valid_q;
    if (wr_push) begin
      wr_data_n  = wr_byte;
      wr_valid_n = 1'b1;
    end else if (wr_ready_i) begin
      wr_valid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr_q <= '0;
      chk_en_q   <= 1'b1;
      wr_data_q  <= '0;
      wr_valid_q <= 1'b0;
    end else begin
      own_addr_q <= own_addr_n;
      chk_en_q   <= chk_en_n;
      wr_data_q  <= wr_data_n;
      wr_valid_q <= wr_valid_n;
    end
  end

  assign wr_data_o  = wr_data_q;
  assign wr_valid_o = wr_valid_q;
endmodule

// File: rtl/spi_hp_port_chk.sv
module spi_hp_port_chk
  import spi_hp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input phase_e            phase,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              wr_push,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              rd_ready_o,
  input logic              rd_valid_i,
  input logic              req_hold,
  input logic              req_n_o
);
  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0 && phase == PH_IDLE));

  a_r2_skip_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SKIP |-> !wr_push);

  a_r9_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready_o |-> rd_valid_i);

  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i && !wr_push) |=> (wr_valid_o && $stable(wr_data_o)));

  a_r8_hold_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_hold |-> req_n_o);

  a_r7_data_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_valid_i) && !req_hold) |-> !req_n_o);

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(DATA_W));
endmodule

bind spi_host_port spi_hp_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .phase(phase), .bit_cnt(bit_cnt),
  .wr_push(wr_push), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
  .wr_data_o(wr_data_o), .rd_ready_o(rd_ready_o), .rd_valid_i(rd_valid_i),
  .req_hold(req_hold), .req_n_o(req_n_o)
);

// File: tb/spi_host_port_bench.sv
module spi_host_port_bench;
  localparam int HALF = 8;

  logic       clk, rst_n;
  logic       sclk_i, cs_n_i, mosi_i;
  logic       miso_o, req_n_o;
  logic       cfg_we_i, cfg_chk_en_i;
  logic [6:0] cfg_addr_i;
  logic [7:0] wr_data_o, rd_data_i;
  logic       wr_valid_o, wr_ready_i, rd_valid_i, rd_ready_o;

  int checks = 0;
  int errors = 0;
  int wr_seen = 0;
  logic [7:0] exp_q[$];
  logic [7:0] src_q[$];

  spi_host_port u_spi_host_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .req_n_o(req_n_o), .cfg_we_i(cfg_we_i),
    .cfg_addr_i(cfg_addr_i), .cfg_chk_en_i(cfg_chk_en_i),
    .wr_data_o(wr_data_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i), .rd_ready_o(rd_ready_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Read source model: pop on accepted pulse, refresh away from the edge
  always @(posedge clk) if (rd_ready_o && rd_valid_i && src_q.size() != 0) void'(src_q.pop_front());
  always @(negedge clk) begin
    rd_valid_i = (src_q.size() != 0);
    rd_data_i  = (src_q.size() != 0) ? src_q[0] : 8'h00;
  end

  // Write monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && wr_valid_o && wr_ready_i) begin
      wr_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected write byte", wr_data_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(wr_data_o == e, "R6 write byte order/value", wr_data_o, e);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic start_txn();
    @(posedge clk); cs_n_i <= 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic end_txn();
    wait_cyc(HALF);
    cs_n_i <= 1'b1; sclk_i <= 1'b0;
    wait_cyc(2 * HALF);
  endtask

  // One byte; full=0 omits the final falling edge; probe checks the hold window
  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx,
                           input bit full, input bit probe, input logic [7:0] inj);
    rx = '0;
    for (int i = 0; i < 8; i++) begin
      mosi_i <= tx[7-i];
      wait_cyc(HALF - 1);
      @(negedge clk);
      rx[7-i] = miso_o;
      if (probe && i == 7) chk(req_n_o == 1'b1, "R8 held high before bit 8 rise", req_n_o, 1);
      @(posedge clk); sclk_i <= 1'b1;
      wait_cyc(HALF - 1);
      @(negedge clk);
      if (probe && i == 6) chk(req_n_o == 1'b1, "R8 high after bit 7 rise", req_n_o, 1);
      if (probe && i == 7) chk(req_n_o == 1'b0, "R7 low again after bit 8 rise", req_n_o, 0);
      @(posedge clk);
      if (probe && i == 6) src_q.push_back(inj);
      if (i < 7 || full) sclk_i <= 1'b0;
    end
  endtask

  task automatic write_txn(input logic [6:0] a, input int n, input logic [7:0] d0,
                           input logic [7:0] d1, input logic [7:0] d2, input bit accept);
    logic [7:0] r;
    logic [7:0] dv [3];
    dv[0] = d0; dv[1] = d1; dv[2] = d2;
    start_txn();
    xfer_byte({a, 1'b0}, r, 1'b1, 1'b0, 8'h00);
    for (int k = 0; k < n; k++) begin
      if (accept) exp_q.push_back(dv[k]);
      xfer_byte(dv[k], r, 1'b1, 1'b0, 8'h00);
    end
    end_txn();
  endtask

  task automatic cfg(input logic [6:0] a, input bit en);
    @(posedge clk); cfg_we_i <= 1'b1; cfg_addr_i <= a; cfg_chk_en_i <= en;
    @(posedge clk); cfg_we_i <= 1'b0;
    wait_cyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int seen0;
    rst_n = 1'b0; sclk_i = 1'b0; cs_n_i = 1'b1; mosi_i = 1'b0;
    cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_chk_en_i = 1'b0; wr_ready_i = 1'b1;
    rd_valid_i = 1'b0; rd_data_i = '0;
    wait_cyc(5);
    @(posedge clk); rst_n <= 1'b1;
    wait_cyc(3);
    @(negedge clk);
    chk(req_n_o == 1'b1, "R1 req_n after reset", req_n_o, 1);
    chk(wr_valid_o == 1'b0, "R1 wr_valid after reset", wr_valid_o, 0);
    chk(miso_o == 1'b0, "R1 miso after reset", miso_o, 0);

    // R3 R6: default address 0 accepts three bytes in order
    write_txn(7'h00, 3, 8'hA5, 8'h3C, 8'h81, 1'b1);
    chk(wr_seen == 3, "R6 three bytes presented", wr_seen, 3);

    // R2: address mismatch ignored
    write_txn(7'h11, 2, 8'h12, 8'h34, 8'h00, 1'b0);
    chk(wr_seen == 3, "R2 mismatched write ignored", wr_seen, 3);

    // R4: new address, and check disable
    cfg(7'h2A, 1'b1);
    write_txn(7'h2A, 1, 8'h5E, 8'h00, 8'h00, 1'b1);
    write_txn(7'h00, 1, 8'h66, 8'h00, 8'h00, 1'b0);
    chk(wr_seen == 4, "R4 programmed address match", wr_seen, 4);
    cfg(7'h2A, 1'b0);
    write_txn(7'h55, 1, 8'hC3, 8'h00, 8'h00, 1'b1);
    chk(wr_seen == 5, "R4 check disabled accepts any address", wr_seen, 5);
    cfg(7'h00, 1'b1);

    // R5 R11: missing final falling edge, then abort by chip select
    seen0 = wr_seen;
    start_txn();
    xfer_byte(8'h00, r, 1'b1, 1'b0, 8'h00);
    xfer_byte(8'hEE, r, 1'b0, 1'b0, 8'h00);
    wait_cyc(3 * HALF);
    @(negedge clk);
    chk(wr_valid_o == 1'b0, "R5 nothing before the eighth falling edge", wr_valid_o, 0);
    end_txn();
    chk(wr_seen == seen0, "R11 partial byte dropped on abort", wr_seen, seen0);
    write_txn(7'h00, 1, 8'h4B, 8'h00, 8'h00, 1'b1);
    chk(wr_seen == seen0 + 1, "R11 fresh transaction after abort", wr_seen, seen0 + 1);

    // R10: valid held while not ready
    @(posedge clk); wr_ready_i <= 1'b0;
    write_txn(7'h00, 1, 8'h96, 8'h00, 8'h00, 1'b1);
    wait_cyc(20);
    @(negedge clk);
    chk(wr_valid_o == 1'b1, "R10 valid held without ready", wr_valid_o, 1);
    chk(wr_data_o == 8'h96, "R10 data stable without ready", wr_data_o, 8'h96);
    @(posedge clk); wr_ready_i <= 1'b1;
    wait_cyc(4);

    // R7 R9: read two bytes then an empty one
    @(posedge clk); src_q.push_back(8'hA5); src_q.push_back(8'h3C);
    wait_cyc(4);
    @(negedge clk);
    chk(req_n_o == 1'b0, "R7 low with data waiting", req_n_o, 0);
    start_txn();
    xfer_byte(8'h01, r, 1'b1, 1'b0, 8'h00);
    xfer_byte(8'h00, r, 1'b1, 1'b0, 8'h00);
    chk(r == 8'hA5, "R9 first read byte", r, 8'hA5);
    xfer_byte(8'h00, r, 1'b1, 1'b0, 8'h00);
    chk(r == 8'h3C, "R9 second read byte", r, 8'h3C);
    @(negedge clk);
    chk(req_n_o == 1'b1, "R7 high when source empty", req_n_o, 1);
    xfer_byte(8'h00, r, 1'b1, 1'b0, 8'h00);
    chk(r == 8'h00, "R9 empty source sends zero", r, 0);
    end_txn();

    // R8: data arrives inside the hold window
    @(posedge clk); src_q.push_back(8'h81);
    wait_cyc(4);
    start_txn();
    xfer_byte(8'h01, r, 1'b1, 1'b0, 8'h00);
    xfer_byte(8'h00, r, 1'b1, 1'b1, 8'h7E);
    chk(r == 8'h81, "R9 read byte before hold", r, 8'h81);
    xfer_byte(8'h00, r, 1'b1, 1'b0, 8'h00);
    chk(r == 8'h7E, "R8 late byte delivered next", r, 8'h7E);
    end_txn();

    // R2: read at a mismatched address pops nothing
    @(posedge clk); src_q.push_back(8'h5A);
    start_txn();
    xfer_byte(8'h23, r, 1'b1, 1'b0, 8'h00);
    xfer_byte(8'h00, r, 1'b1, 1'b0, 8'h00);
    end_txn();
    chk(src_q.size() == 1, "R2 mismatched read pops nothing", src_q.size(), 1);
    @(negedge clk);
    chk(req_n_o == 1'b0, "R7 still requesting after ignored read", req_n_o, 0);

    wait_cyc(10);
    chk(exp_q.size() == 0, "R6 all expected bytes presented", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule